// File: doc/BRIEF.md
# Comma-Aligned Word Deserializer

This block takes a stream of already retimed serial bits, one bit per clock, and packs them into parallel words of either 10 or 20 bits. It does not recover a clock and it does not decode 8b/10b. A loopback-enable input chooses where the bits come from: the line input or the loopback input.

When framing is enabled, the block compares the ten most recent bits against the positive-disparity K28.5 comma after every received bit. A match moves the word boundary so that the comma fills one complete 10-bit lane of the next word emitted. Any word still being assembled at that point is abandoned. When framing is disabled, words are cut on a free-running bit count and no comma search takes place.

Each finished word raises a one-cycle strobe. The data and the sync flag then hold their values until the next strobe. The sync flag marks a word whose comma lane holds the comma.

Top module: `comma_deser`

## Requirements
- R1: While reset is asserted, `word_valid` and `sync_out` are 0 and `word_out` is all ones. After reset is released, the first word is cut after exactly 10 bits (narrow mode) or 20 bits (wide mode).
- R2: When `loop_en` is 1, the received bit is taken from `loop_bit`. When `loop_en` is 0, it is taken from `line_bit`. The input that is not selected has no effect on `word_out`.
- R3: In narrow mode (`narrow_sel` = 1), each word holds 10 bits. The k-th bit received in the word appears at `word_out[10+k]`, and `word_out[9:0]` is driven all ones.
- R4: In wide mode (`narrow_sel` = 0), each word holds 20 bits, and the k-th bit received in the word appears at `word_out[k]`.
- R5: With `frame_en` = 0, a strobe follows every 10 bits (narrow) or every 20 bits (wide), and a comma in the stream does not move the boundary.
- R6: With `frame_en` = 1 in narrow mode, the bit that completes the comma (received order 0,0,1,1,1,1,1,0,1,0) cuts a word at once, with `sync_out` = 1. Later words follow every 10 bits from that point.
- R7: With `frame_en` = 1 in wide mode, a comma becomes bits 0 to 9 of the next word. No strobe is issued at the boundary that was pending. The next strobe comes 10 bits after the bit that completed the comma.
- R8: A comma that already sits on the current boundary leaves the strobe spacing unchanged.
- R9: `sync_out` is 1 from a strobe whose comma lane holds the comma until the next strobe, and 0 otherwise. The comma lane is bits 10 to 19 in narrow mode and bits 0 to 9 in wide mode. Read from bit 19 down to bit 10, a narrow comma is 0101111100.
- R10: On the first clock at which `narrow_sel` is sampled 1 after being 0, the bit count restarts. The bit taken in that clock belongs to no word, and the next word is cut 10 bits later.
- R11: On the first clock at which `frame_en` is sampled 0 after being 1, the bit count restarts in the same way, so any earlier comma alignment is dropped.
- R12: `word_valid` is high for one clock per word. `word_out` and `sync_out` change only on a clock where `word_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_bit | input | 1 | Serial bit from the line |
| loop_bit | input | 1 | Serial bit from the loopback path |
| loop_en | input | 1 | 1 selects `loop_bit`, 0 selects `line_bit` |
| narrow_sel | input | 1 | 1 gives 10-bit words, 0 gives 20-bit words; a rising edge restarts the count |
| frame_en | input | 1 | 1 enables the comma search; a falling edge restarts the count |
| word_valid | output | 1 | One-cycle strobe for each finished word |
| word_out | output | 20 | Parallel word, held between strobes |
| sync_out | output | 1 | Comma present in the comma lane of the held word |

## Verification
The assertions assume that one valid bit arrives on every clock. They also assume that `narrow_sel` and `frame_en` change only at a bit, so the fixed strobe spacing is checked only after a long window in which both inputs stayed steady and framing was off. The stimulus drives every bit and every mode change shortly after a rising edge. It changes the modes only during reset or in the scenarios that test a restart. The filler and data patterns are chosen so that no comma can form across them apart from the commas placed on purpose.

// File: rtl/comma_deser_pkg.sv
`timescale 1ns/1ps
package comma_deser_pkg;

  // What the word timer does with the current bit
  typedef enum logic [1:0] {
    ACT_COUNT   = 2'd0,
    ACT_EMIT    = 2'd1,
    ACT_ALIGN   = 2'd2,
    ACT_RESTART = 2'd3
  } tmr_act_e;

  // Bits per word for the selected width
  function automatic int unsigned word_bits(input logic narrow, input int unsigned lane_w);
    return narrow ? lane_w : 2 * lane_w;
  endfunction

  // Count value loaded when the comma completes: in wide mode the comma
  // fills the first lane, so the word is half complete
  function automatic int unsigned align_count(input logic narrow, input int unsigned lane_w);
    return narrow ? 0 : lane_w;
  endfunction

endpackage

// File: rtl/cd_input_sel.sv
`timescale 1ns/1ps
module cd_input_sel (
  input  logic loop_en,
  input  logic line_bit,
  input  logic loop_bit,
  output logic bit_sel
);
  assign bit_sel = loop_en ? loop_bit : line_bit;
endmodule

// File: rtl/cd_shifter.sv
`timescale 1ns/1ps
module cd_shifter #(
  parameter int unsigned WORD_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_in,
  output logic [WORD_W-1:0] hist_nxt
);
  logic [WORD_W-1:0] hist_q;

  // newest bit enters at the top; index 0 is the oldest of the window
  assign hist_nxt = {bit_in, hist_q[WORD_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end
endmodule

// File: rtl/cd_comma_match.sv
`timescale 1ns/1ps
module cd_comma_match #(
  parameter int unsigned          LANE_W   = 10,
  parameter logic [LANE_W-1:0]    COMMA_AJ = 10'b0011111010
) (
  input  logic [LANE_W-1:0] window,
  output logic              hit
);
  // COMMA_AJ holds the first received bit in its MSB; the window holds it at index 0
  logic [LANE_W-1:0] img;

  for (genvar k = 0; k < LANE_W; k++) begin : g_img
    assign img[k] = COMMA_AJ[LANE_W-1-k];
  end

  assign hit = (window == img);
endmodule

// File: rtl/cd_word_timer.sv
`timescale 1ns/1ps
module cd_word_timer
  import comma_deser_pkg::*;
#(
  parameter int unsigned LANE_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic narrow_sel,
  input  logic frame_en,
  input  logic comma_hit,
  output logic emit,
  output logic restart
);
  localparam int unsigned WORD_W = 2 * LANE_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W);

  logic [CNT_W-1:0] cnt_q, cnt_d, last_idx, align_idx;
  logic             narrow_q, frame_q, use_comma;
  tmr_act_e         act;

  always_comb begin
    last_idx  = CNT_W'(word_bits(narrow_sel, LANE_W) - 1);
    align_idx = CNT_W'(align_count(narrow_sel, LANE_W));
    restart   = (narrow_sel & ~narrow_q) | (frame_q & ~frame_en);
    use_comma = frame_en & comma_hit & ~restart;

    if (restart)               act = ACT_RESTART;
    else if (use_comma)        act = ACT_ALIGN;
    else if (cnt_q == last_idx) act = ACT_EMIT;
    else                       act = ACT_COUNT;

    case (act)
      ACT_RESTART: begin cnt_d = '0;           emit = 1'b0;       end
      ACT_ALIGN:   begin cnt_d = align_idx;    emit = narrow_sel; end
      ACT_EMIT:    begin cnt_d = '0;           emit = 1'b1;       end
      default:     begin cnt_d = cnt_q + 1'b1; emit = 1'b0;       end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      narrow_q <= 1'b1;
      frame_q  <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      narrow_q <= narrow_sel;
      frame_q  <= frame_en;
    end
  end
endmodule

// File: rtl/comma_deser.sv
`timescale 1ns/1ps
module comma_deser #(
  parameter int unsigned       LANE_W   = 10,
  parameter logic [LANE_W-1:0] COMMA_AJ = 10'b0011111010
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_bit,
  input  logic                  loop_bit,
  input  logic                  loop_en,
  input  logic                  narrow_sel,
  input  logic                  frame_en,
  output logic                  word_valid,
  output logic [2*LANE_W-1:0]   word_out,
  output logic                  sync_out
);
  localparam int unsigned WORD_W = 2 * LANE_W;

  logic              bit_sel, comma_hit, lane_hit, emit, restart;
  logic [WORD_W-1:0] hist_nxt, word_nxt;
  logic [LANE_W-1:0] out_lane;

  cd_input_sel u_sel (
    .loop_en (loop_en),
    .line_bit(line_bit),
    .loop_bit(loop_bit),
    .bit_sel (bit_sel)
  );

  cd_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_sel),
    .hist_nxt(hist_nxt)
  );

  // search window: the last LANE_W bits, checked at every bit
  cd_comma_match #(.LANE_W(LANE_W), .COMMA_AJ(COMMA_AJ)) u_search (
    .window(hist_nxt[WORD_W-1:LANE_W]),
    .hit   (comma_hit)
  );

  cd_word_timer #(.LANE_W(LANE_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .narrow_sel(narrow_sel),
    .frame_en  (frame_en),
    .comma_hit (comma_hit),
    .emit      (emit),
    .restart   (restart)
  );

  // comma lane of the word being emitted
  assign out_lane = narrow_sel ? hist_nxt[WORD_W-1:LANE_W] : hist_nxt[LANE_W-1:0];

  cd_comma_match #(.LANE_W(LANE_W), .COMMA_AJ(COMMA_AJ)) u_lane (
    .window(out_lane),
    .hit   (lane_hit)
  );

  assign word_nxt = narrow_sel ? {hist_nxt[WORD_W-1:LANE_W], {LANE_W{1'b1}}} : hist_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_out   <= '1;
      sync_out   <= 1'b0;
    end else begin
      word_valid <= emit;
      if (emit) begin
        word_out <= word_nxt;
        sync_out <= lane_hit;
      end
    end
  end
endmodule

// File: rtl/cd_checker.sv
`timescale 1ns/1ps
module cd_checker #(
  parameter int unsigned       LANE_W   = 10,
  parameter logic [LANE_W-1:0] COMMA_AJ = 10'b0011111010
) (
  input logic                clk,
  input logic                rst_n,
  input logic                narrow_sel,
  input logic                frame_en,
  input logic                word_valid,
  input logic [2*LANE_W-1:0] word_out,
  input logic                sync_out,
  input logic                comma_hit,
  input logic                restart
);
  function automatic logic [LANE_W-1:0] arrival_image(input logic [LANE_W-1:0] aj);
    logic [LANE_W-1:0] r;
    for (int i = 0; i < LANE_W; i++) r[i] = aj[LANE_W-1-i];
    return r;
  endfunction

  localparam logic [LANE_W-1:0] IMG = arrival_image(COMMA_AJ);

  logic        narrow_d, seen;
  int unsigned gap, quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_d <= 1'b1;
      seen     <= 1'b0;
      gap      <= 0;
      quiet    <= 0;
    end else begin
      narrow_d <= narrow_sel;
      if (word_valid) begin
        gap  <= 1;
        seen <= 1'b1;
      end else if (gap < 1000) begin
        gap <= gap + 1;
      end
      if (frame_en || (narrow_sel != narrow_d)) quiet <= 0;
      else if (quiet < 1000)                    quiet <= quiet + 1;
    end
  end

  // R9: a flagged word carries the comma in its lane
  a_r9_sync_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && sync_out) |->
      (($past(narrow_sel) ? word_out[2*LANE_W-1:LANE_W] : word_out[LANE_W-1:0]) == IMG));

  // R12: outputs hold between strobes
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> ($stable(word_out) && $stable(sync_out)));

  // R3: low lane is all ones for narrow words
  a_r3_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(narrow_sel)) |-> (word_out[LANE_W-1:0] == {LANE_W{1'b1}}));

  // R6: a narrow comma cuts a flagged word at once
  a_r6_comma_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_hit && frame_en && narrow_sel && !restart) |=> (word_valid && sync_out));

  // R7: a wide comma never cuts a word on the bit that completes it
  a_r7_wide_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (comma_hit && frame_en && !narrow_sel && !restart) |=> !word_valid);

  // R5: unframed strobes follow the fixed word length
  a_r5_fixed_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen && !frame_en && quiet >= 3 * LANE_W) |->
      (gap == (narrow_sel ? LANE_W : 2 * LANE_W)));
endmodule

bind comma_deser cd_checker #(.LANE_W(LANE_W), .COMMA_AJ(COMMA_AJ)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .narrow_sel(narrow_sel),
  .frame_en  (frame_en),
  .word_valid(word_valid),
  .word_out  (word_out),
  .sync_out  (sync_out),
  .comma_hit (comma_hit),
  .restart   (restart)
);

// File: tb/comma_deser_test.sv
`timescale 1ns/1ps
module comma_deser_test;
  localparam logic [9:0] COMMA    = 10'b0011111010; // first received bit in MSB
  localparam logic [9:0] COMMA_HI = 10'b0101111100; // bits 19..10 in narrow mode
  localparam logic [9:0] ALT      = 10'b1010101010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_bit = 1'b0, loop_bit = 1'b0, loop_en = 1'b0;
  logic        narrow_sel = 1'b1, frame_en = 1'b0;
  logic        word_valid, sync_out;
  logic [19:0] word_out;

  int total = 0, bad = 0;
  int nbits = 0, strobe_cnt = 0, last_at = 0;
  logic sent [0:127];

  comma_deser uut (
    .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .loop_bit(loop_bit),
    .loop_en(loop_en), .narrow_sel(narrow_sel), .frame_en(frame_en),
    .word_valid(word_valid), .word_out(word_out), .sync_out(sync_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp10(input int start);
    logic [19:0] e = '1;
    for (int k = 0; k < 10; k++) e[10+k] = sent[start+k];
    return e;
  endfunction

  function automatic logic [19:0] exp20(input int start);
    logic [19:0] e;
    for (int k = 0; k < 20; k++) e[k] = sent[start+k];
    return e;
  endfunction

  task automatic do_reset(input logic nar, input logic frm, input logic lp);
    rst_n = 1'b0;
    narrow_sel = nar; frame_en = frm; loop_en = lp;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", 32'(word_valid), 32'd0);
    chk("R1 sync in reset", 32'(sync_out), 32'd0);
    chk("R1 word in reset", 32'(word_out), 32'hFFFFF);
    rst_n = 1'b1;
    nbits = 0; strobe_cnt = 0; last_at = 0;
  endtask

  // one bit per clock; the unselected input gets the complement
  task automatic push(input logic b);
    if (loop_en) begin loop_bit = b; line_bit = ~b; end
    else         begin line_bit = b; loop_bit = ~b; end
    sent[nbits] = b;
    @(posedge clk);
    #1;
    nbits++;
    if (word_valid) begin strobe_cnt++; last_at = nbits; end
  endtask

  task automatic push10(input logic [9:0] v);
    for (int i = 9; i >= 0; i--) push(v[i]);
  endtask

  task automatic zeros(input int n);
    for (int i = 0; i < n; i++) push(1'b0);
  endtask

  task automatic t_unframed10;
    do_reset(1'b1, 1'b0, 1'b0);
    push10(10'b1101000110);
    chk("R1 first narrow word after 10 bits", 32'(strobe_cnt), 32'd1);
    chk("R3 narrow packing", 32'(word_out), 32'(exp10(0)));
    zeros(3);
    push10(COMMA);
    chk("R5 unframed strobe count", 32'(strobe_cnt), 32'd2);
    chk("R5 unframed strobe position", 32'(last_at), 32'd20);
    chk("R9 unaligned word not flagged", 32'(sync_out), 32'd0);
    zeros(7);
    chk("R5 unframed spacing kept", 32'(last_at), 32'd30);
  endtask

  task automatic t_unframed20;
    do_reset(1'b0, 1'b0, 1'b0);
    push10(10'h2D5);
    chk("R4 no strobe at 10 bits", 32'(strobe_cnt), 32'd0);
    push10(10'h0F3);
    chk("R1 first wide word after 20 bits", 32'(last_at), 32'd20);
    chk("R4 wide packing", 32'(word_out), 32'(exp20(0)));
  endtask

  task automatic t_framed10;
    do_reset(1'b1, 1'b1, 1'b0);
    zeros(4);
    push10(COMMA);
    chk("R6 strobe on comma", 32'(last_at), 32'd14);
    chk("R6 strobe count", 32'(strobe_cnt), 32'd2);
    chk("R9 sync on comma word", 32'(sync_out), 32'd1);
    chk("R9 comma lane image", 32'(word_out[19:10]), 32'(COMMA_HI));
    chk("R3 comma word packing", 32'(word_out), 32'(exp10(4)));
    push(1'b1);
    chk("R12 strobe is one cycle", 32'(word_valid), 32'd0);
    chk("R12 word held", 32'(word_out), 32'(exp10(4)));
    push(1'b0); push(1'b1); push(1'b0); push(1'b1);
    chk("R9 sync held through word period", 32'(sync_out), 32'd1);
    push(1'b0); push(1'b1); push(1'b0); push(1'b1); push(1'b0);
    chk("R6 next word 10 bits after comma", 32'(last_at), 32'd24);
    chk("R9 sync low on data word", 32'(sync_out), 32'd0);
    push10(COMMA);
    chk("R8 aligned comma keeps spacing", 32'(last_at), 32'd34);
    chk("R8 aligned comma strobe count", 32'(strobe_cnt), 32'd4);
    chk("R9 sync on aligned comma", 32'(sync_out), 32'd1);
    push10(ALT);
    chk("R8 spacing after aligned comma", 32'(last_at), 32'd44);
  endtask

  task automatic t_framed20;
    do_reset(1'b0, 1'b1, 1'b0);
    zeros(7);
    push10(COMMA);
    push(1'b1); push(1'b0); push(1'b1);
    chk("R7 pending boundary abandoned", 32'(strobe_cnt), 32'd0);
    push(1'b0); push(1'b1); push(1'b0); push(1'b1);
    push(1'b0); push(1'b1); push(1'b0);
    chk("R7 strobe 10 bits after comma", 32'(last_at), 32'd27);
    chk("R7 single strobe", 32'(strobe_cnt), 32'd1);
    chk("R7 comma in low lane", 32'(word_out[9:0]), 32'(COMMA_HI));
    chk("R4 wide framed packing", 32'(word_out), 32'(exp20(7)));
    chk("R9 sync on wide comma word", 32'(sync_out), 32'd1);
  endtask

  task automatic t_loop;
    do_reset(1'b1, 1'b0, 1'b1);
    push10(10'b1100101001);
    chk("R2 loopback input selected", 32'(word_out), 32'(exp10(0)));
    loop_en = 1'b0;
    push10(10'b0110011101);
    chk("R2 line input selected", 32'(word_out), 32'(exp10(10)));
  endtask

  task automatic t_width_rise;
    do_reset(1'b0, 1'b0, 1'b0);
    push(1'b1); push(1'b0); push(1'b1); push(1'b1); push(1'b0);
    narrow_sel = 1'b1;
    push(1'b1);
    for (int i = 0; i < 9; i++) push(i[0]);
    chk("R10 no strobe before restarted word ends", 32'(strobe_cnt), 32'd0);
    push(1'b1);
    chk("R10 strobe 10 bits after restart", 32'(last_at), 32'd16);
    chk("R10 restarted word contents", 32'(word_out), 32'(exp10(6)));
  endtask

  task automatic t_frame_drop;
    int base;
    do_reset(1'b1, 1'b1, 1'b0);
    zeros(4);
    push10(COMMA);
    push10(ALT);
    push(1'b1); push(1'b0); push(1'b1);
    frame_en = 1'b0;
    push(1'b0);
    base = strobe_cnt;
    for (int i = 0; i < 9; i++) push(i[0]);
    chk("R11 old alignment dropped", 32'(strobe_cnt), 32'(base));
    push(1'b1);
    chk("R11 strobe 10 bits after restart", 32'(last_at), 32'd38);
    chk("R11 restarted word contents", 32'(word_out), 32'(exp10(28)));
  endtask

  initial begin
    t_unframed10();
    t_unframed20();
    t_framed10();
    t_framed20();
    t_loop();
    t_width_rise();
    t_frame_drop();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule